// File: doc/BRIEF.md
# Mailbox Command Issue Sequencer

This block is the console-side driver for a small register mailbox on a cartridge. Local logic hands it one request: a command with an 8-bit identifier and two 32-bit arguments, a presence probe, an unlock or a lock. The sequencer then performs the word reads and writes on a valid/ready master port in a fixed order and returns one response.

A command passes through these states. S_WR_ARG0 and S_WR_ARG1 write the arguments. S_GATE reads status until the busy flag is clear, and S_WR_CMD writes the command word. Completion is then awaited in one of two ways. In polled mode, S_POLL re-reads status. In interrupt mode, S_WAIT_IRQ waits for the cart interrupt, S_CONFIRM reads status, and S_WR_ACK clears the pending bit. S_RD_DATA0 and S_RD_DATA1 fetch the results, and S_RESPOND strobes the response. A probe uses S_RD_ID and then S_ID_BUSY. An unlock uses S_WR_KEY_A and then S_WR_KEY_B. A lock uses S_WR_LOCK. Every operation leaves through S_RESPOND and returns to S_IDLE. A cycle counter, cleared when a request is accepted, ends any wait that runs too long, so the block cannot hang.

Register addresses are the base address plus a byte offset: status/command +0x00, first data word +0x04, second data word +0x08, identifier +0x0C, key +0x10, interrupt control +0x14.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1, and bus_valid and rsp_valid are 0.
- R2: For a command (req_op 0) with req_skip_args 0, the block writes req_arg0 to +0x04 and then req_arg1 to +0x08, before any other access. With req_skip_args 1, both writes are left out.
- R3: Before the command write, the block reads status (+0x00). It repeats the read while bit 31 (busy) is 1. The command write is issued only after a status read has returned bit 31 clear.
- R4: The command write goes to +0x00. Its data carries the command identifier in bits [7:0], req_use_irq in bit 8, and zeros in bits [31:9].
- R5: In polled mode, after the command write, status is re-read until bit 31 is 0. Bit 30 of that read is taken as the error flag.
- R6: In interrupt mode, the block waits for cart_irq and then reads status. If bit 27 is set, it writes 0x4000_0000 to +0x14 and takes bit 30 of that status read as the error flag. If bit 27 is clear, the response is code 4 with no acknowledge write.
- R7: If the error flag is set, only +0x04 is read, and the response is code 1 with word0 holding the error code and word1 = 0. Otherwise +0x04 and +0x08 are read, and the response is code 0 with word0 and word1 holding the two results.
- R8: A probe (req_op 1) reads +0x0C. If the value is 0x5343_7632, it reads status until bit 31 clears and responds with code 0 and word0 = the identifier. Any other value gives code 3 with word0 = the value read, and no further access.
- R9: An unlock (req_op 2) writes the KEY_WORD_A parameter and then 0x4F43_4B5F to +0x10. A lock (req_op 3) writes 0xFFFF_FFFF to +0x10. Both respond with code 0.
- R10: A counter is cleared when a request is accepted and counts clock cycles. Once it has reached tmo_limit, a wait ends with code 2. A wait ends this way either when a status read still shows busy or on an interrupt-wait cycle without cart_irq.
- R11: rsp_valid is high for exactly one clock per request. req_ready is 0 from acceptance until after that strobe.
- R12: While bus_valid is 1 and bus_ready is 0, bus_valid, bus_write, bus_addr and bus_wdata hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_op | input | 2 | 0 command, 1 probe, 2 unlock, 3 lock |
| req_cmd_id | input | 8 | Command identifier |
| req_arg0 | input | 32 | First argument |
| req_arg1 | input | 32 | Second argument |
| req_use_irq | input | 1 | 1 = interrupt completion, 0 = polled |
| req_skip_args | input | 1 | 1 = no argument writes |
| tmo_limit | input | TMO_W | Wait limit in cycles |
| cart_irq | input | 1 | Cart interrupt level |
| bus_valid | output | 1 | Bus access requested |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Access completes this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | 0 ok, 1 command error, 2 timeout, 3 absent, 4 no pending |
| rsp_word0 | output | 32 | Result 0, error code or identifier |
| rsp_word1 | output | 32 | Result 1 |

## Verification
The two functions that can fall in the same cycle are the command-write completion and the cart interrupt. When a command finishes with zero latency, the slave model raises cart_irq on the very edge where the command write is accepted, before the sequencer has reached its interrupt wait. The random mix includes that zero latency case. The check is that the bus sequence still reads status once, acknowledges exactly once and fetches the results, with the expected response code.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CMD_ID_W = 8;

    // register byte offsets from the window base
    localparam logic [WORD_W-1:0] OFS_STATUS = 32'h0000_0000;
    localparam logic [WORD_W-1:0] OFS_DATA0  = 32'h0000_0004;
    localparam logic [WORD_W-1:0] OFS_DATA1  = 32'h0000_0008;
    localparam logic [WORD_W-1:0] OFS_IDENT  = 32'h0000_000C;
    localparam logic [WORD_W-1:0] OFS_KEY    = 32'h0000_0010;
    localparam logic [WORD_W-1:0] OFS_IRQCTL = 32'h0000_0014;

    // status bit positions read by the sequencer
    localparam int unsigned BIT_BUSY     = 31;
    localparam int unsigned BIT_ERR      = 30;
    localparam int unsigned BIT_CMD_PEND = 27;
    localparam int unsigned BIT_ACK      = 30;

    localparam logic [WORD_W-1:0] IDENT_MAGIC = 32'h5343_7632;
    localparam logic [WORD_W-1:0] KEY_WORD_B  = 32'h4F43_4B5F;
    localparam logic [WORD_W-1:0] KEY_LOCK    = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        OP_COMMAND = 2'd0,
        OP_PROBE   = 2'd1,
        OP_UNLOCK  = 2'd2,
        OP_LOCK    = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_CMD_ERR = 3'd1,
        RC_TIMEOUT = 3'd2,
        RC_ABSENT  = 3'd3,
        RC_NO_PEND = 3'd4
    } rsp_code_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_WR_ARG0,
        S_WR_ARG1,
        S_GATE,
        S_WR_CMD,
        S_POLL,
        S_WAIT_IRQ,
        S_CONFIRM,
        S_WR_ACK,
        S_RD_DATA0,
        S_RD_DATA1,
        S_RD_ID,
        S_ID_BUSY,
        S_WR_KEY_A,
        S_WR_KEY_B,
        S_WR_LOCK,
        S_RESPOND
    } seq_state_e;

    typedef struct packed {
        op_e                 op;
        logic [CMD_ID_W-1:0] cmd_id;
        logic [WORD_W-1:0]   arg0;
        logic [WORD_W-1:0]   arg1;
        logic                use_irq;
        logic                skip_args;
    } req_t;

endpackage

// File: rtl/mbox_req_hold.sv
module mbox_req_hold
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  req_t d,
    output req_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/mbox_wait_timer.sv
module mbox_wait_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
    import mbox_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h1FFF_0000,
    parameter logic [31:0] KEY_WORD_A = 32'h5F55_4E4C,
    parameter int unsigned TMO_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [7:0]       req_cmd_id,
    input  logic [31:0]      req_arg0,
    input  logic [31:0]      req_arg1,
    input  logic             req_use_irq,
    input  logic             req_skip_args,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             cart_irq,
    output logic             bus_valid,
    output logic             bus_write,
    output logic [31:0]      bus_addr,
    output logic [31:0]      bus_wdata,
    input  logic             bus_ready,
    input  logic [31:0]      bus_rdata,
    output logic             rsp_valid,
    output logic [2:0]       rsp_code,
    output logic [31:0]      rsp_word0,
    output logic [31:0]      rsp_word1
);

    localparam int unsigned CMD_PAD_W = WORD_W - CMD_ID_W - 1;
    localparam logic [WORD_W-1:0] ACK_WORD = WORD_W'(1) << BIT_ACK;

    seq_state_e state_q, state_d;
    req_t       req_in, req_q;
    rsp_code_e  code_q;
    logic [WORD_W-1:0] word0_q, word1_q;
    logic       err_q;
    logic       accept, xfer, seen_busy, expired;

    assign req_in = '{op: op_e'(req_op), cmd_id: req_cmd_id, arg0: req_arg0,
                      arg1: req_arg1, use_irq: req_use_irq, skip_args: req_skip_args};
    assign accept    = req_valid && (state_q == S_IDLE);
    assign xfer      = bus_valid && bus_ready;
    assign seen_busy = bus_rdata[BIT_BUSY];

    mbox_req_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .d     (req_in),
        .q     (req_q)
    );

    mbox_wait_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (state_q != S_IDLE),
        .limit   (tmo_limit),
        .expired (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    unique case (op_e'(req_op))
                        OP_COMMAND: state_d = req_skip_args ? S_GATE : S_WR_ARG0;
                        OP_PROBE:   state_d = S_RD_ID;
                        OP_UNLOCK:  state_d = S_WR_KEY_A;
                        OP_LOCK:    state_d = S_WR_LOCK;
                        default:    state_d = S_IDLE;
                    endcase
                end
            end
            S_WR_ARG0:  if (xfer) state_d = S_WR_ARG1;
            S_WR_ARG1:  if (xfer) state_d = S_GATE;
            S_GATE: begin
                if (xfer) begin
                    if (!seen_busy)  state_d = S_WR_CMD;
                    else if (expired) state_d = S_RESPOND;
                end
            end
            S_WR_CMD:   if (xfer) state_d = req_q.use_irq ? S_WAIT_IRQ : S_POLL;
            S_POLL: begin
                if (xfer) begin
                    if (!seen_busy)  state_d = S_RD_DATA0;
                    else if (expired) state_d = S_RESPOND;
                end
            end
            S_WAIT_IRQ: begin
                if (cart_irq)     state_d = S_CONFIRM;
                else if (expired) state_d = S_RESPOND;
            end
            S_CONFIRM:  if (xfer) state_d = bus_rdata[BIT_CMD_PEND] ? S_WR_ACK : S_RESPOND;
            S_WR_ACK:   if (xfer) state_d = S_RD_DATA0;
            S_RD_DATA0: if (xfer) state_d = err_q ? S_RESPOND : S_RD_DATA1;
            S_RD_DATA1: if (xfer) state_d = S_RESPOND;
            S_RD_ID:    if (xfer) state_d = (bus_rdata == IDENT_MAGIC) ? S_ID_BUSY : S_RESPOND;
            S_ID_BUSY: begin
                if (xfer && (!seen_busy || expired)) state_d = S_RESPOND;
            end
            S_WR_KEY_A: if (xfer) state_d = S_WR_KEY_B;
            S_WR_KEY_B: if (xfer) state_d = S_RESPOND;
            S_WR_LOCK:  if (xfer) state_d = S_RESPOND;
            S_RESPOND:  state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= RC_OK;
            word0_q <= '0;
            word1_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            code_q  <= RC_OK;
            word0_q <= '0;
            word1_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_GATE, S_ID_BUSY: begin
                    if (xfer && seen_busy && expired) code_q <= RC_TIMEOUT;
                end
                S_POLL: begin
                    if (xfer) begin
                        if (!seen_busy)   err_q  <= bus_rdata[BIT_ERR];
                        else if (expired) code_q <= RC_TIMEOUT;
                    end
                end
                S_WAIT_IRQ: begin
                    if (!cart_irq && expired) code_q <= RC_TIMEOUT;
                end
                S_CONFIRM: begin
                    if (xfer) begin
                        err_q <= bus_rdata[BIT_ERR];
                        if (!bus_rdata[BIT_CMD_PEND]) code_q <= RC_NO_PEND;
                    end
                end
                S_RD_DATA0: begin
                    if (xfer) begin
                        word0_q <= bus_rdata;
                        if (err_q) code_q <= RC_CMD_ERR;
                    end
                end
                S_RD_DATA1: if (xfer) word1_q <= bus_rdata;
                S_RD_ID: begin
                    if (xfer) begin
                        word0_q <= bus_rdata;
                        if (bus_rdata != IDENT_MAGIC) code_q <= RC_ABSENT;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_RESPOND);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = BASE_ADDR + OFS_STATUS;
        bus_wdata = '0;
        unique case (state_q)
            S_WR_ARG0: begin
                bus_valid = 1'b1; bus_write = 1'b1;
                bus_addr  = BASE_ADDR + OFS_DATA0; bus_wdata = req_q.arg0;
            end
            S_WR_ARG1: begin
                bus_valid = 1'b1; bus_write = 1'b1;
                bus_addr  = BASE_ADDR + OFS_DATA1; bus_wdata = req_q.arg1;
            end
            S_GATE, S_POLL, S_CONFIRM, S_ID_BUSY: begin
                bus_valid = 1'b1;
                bus_addr  = BASE_ADDR + OFS_STATUS;
            end
            S_WR_CMD: begin
                bus_valid = 1'b1; bus_write = 1'b1;
                bus_addr  = BASE_ADDR + OFS_STATUS;
                bus_wdata = {{CMD_PAD_W{1'b0}}, req_q.use_irq, req_q.cmd_id};
            end
            S_WR_ACK: begin
                bus_valid = 1'b1; bus_write = 1'b1;
                bus_addr  = BASE_ADDR + OFS_IRQCTL; bus_wdata = ACK_WORD;
            end
            S_RD_DATA0: begin
                bus_valid = 1'b1; bus_addr = BASE_ADDR + OFS_DATA0;
            end
            S_RD_DATA1: begin
                bus_valid = 1'b1; bus_addr = BASE_ADDR + OFS_DATA1;
            end
            S_RD_ID: begin
                bus_valid = 1'b1; bus_addr = BASE_ADDR + OFS_IDENT;
            end
            S_WR_KEY_A: begin
                bus_valid = 1'b1; bus_write = 1'b1;
                bus_addr  = BASE_ADDR + OFS_KEY; bus_wdata = KEY_WORD_A;
            end
            S_WR_KEY_B: begin
                bus_valid = 1'b1; bus_write = 1'b1;
                bus_addr  = BASE_ADDR + OFS_KEY; bus_wdata = KEY_WORD_B;
            end
            S_WR_LOCK: begin
                bus_valid = 1'b1; bus_write = 1'b1;
                bus_addr  = BASE_ADDR + OFS_KEY; bus_wdata = KEY_LOCK;
            end
            default: ;
        endcase
    end

    assign rsp_code  = code_q;
    assign rsp_word0 = word0_q;
    assign rsp_word1 = word1_q;

endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk #(
    parameter logic [31:0] BASE_ADDR = 32'h1FFF_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ready,
    input logic [31:0] bus_rdata,
    input logic        rsp_valid
);

    logic last_busy_q;

    // busy as last observed by a completed status read; a command write re-arms it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_busy_q <= 1'b1;
        end else if (bus_valid && bus_ready && (bus_addr == BASE_ADDR)) begin
            last_busy_q <= bus_write ? 1'b1 : bus_rdata[31];
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_valid && !rsp_valid)); // R1

    AST_CMD_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_write && bus_addr == BASE_ADDR) |-> !last_busy_q); // R3

    AST_CMD_WORD_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == BASE_ADDR) |-> (bus_wdata[31:9] == 23'd0)); // R4

    AST_ACK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == BASE_ADDR + 32'h14) |-> (bus_wdata == 32'h4000_0000)); // R6

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                       && $stable(bus_write) && $stable(bus_wdata))); // R12

endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .rsp_valid (rsp_valid)
);

// File: tb/sim_mbox_cmd_seq.sv
module sim_mbox_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE  = 32'h1FFF_0000;
    localparam logic [31:0] KEY_A = 32'h5F55_4E4C;
    localparam logic [31:0] MAGIC = 32'h5343_7632;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_cmd_id = 8'd0;
    logic [31:0] req_arg0 = '0, req_arg1 = '0;
    logic req_use_irq = 1'b0, req_skip_args = 1'b0;
    logic [15:0] tmo_limit = 16'hFFFF;
    logic cart_irq = 1'b0;
    logic bus_valid, bus_write, bus_ready = 1'b0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic rsp_valid;
    logic [2:0] rsp_code;
    logic [31:0] rsp_word0, rsp_word1;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_cmd_seq #(.BASE_ADDR(BASE), .KEY_WORD_A(KEY_A), .TMO_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_cmd_id(req_cmd_id), .req_arg0(req_arg0), .req_arg1(req_arg1),
        .req_use_irq(req_use_irq), .req_skip_args(req_skip_args), .tmo_limit(tmo_limit),
        .cart_irq(cart_irq), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_word0(rsp_word0), .rsp_word1(rsp_word1)
    );

    // ---------------- slave model ----------------
    int          s_busy = 0, s_lat = 0;
    bit          s_err = 0, s_err_cfg = 0, s_pend = 0, s_irqreq = 0;
    bit          s_fake_mode = 0, s_fake_irq = 0, s_cmd_while_busy = 0;
    logic [31:0] s_id = MAGIC, s_d0 = '0, s_d1 = '0;

    logic [31:0] lg_addr [64];
    bit          lg_wr   [64];
    logic [31:0] lg_data [64];
    int          lg_n = 0;
    logic [31:0] ex_addr [64];
    bit          ex_wr   [64];
    logic [31:0] ex_data [64];
    int          ex_n = 0;

    function automatic logic [31:0] sl_read(input logic [31:0] a);
        case (a - BASE)
            32'h00: return {(s_busy > 0), (s_err && s_busy == 0), 2'b00, s_pend, 27'd0};
            32'h04: return s_d0;
            32'h08: return s_d1;
            32'h0C: return s_id;
            default: return 32'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (s_busy > 0) begin
            s_busy = s_busy - 1;
            if (s_busy == 0) s_pend = 1;
        end
        bus_ready = 1'b0;
        if (rst_n && bus_valid && ($urandom % 3 != 0)) begin
            bus_ready = 1'b1;
            bus_rdata = bus_write ? 32'd0 : sl_read(bus_addr);
            if (!(!bus_write && bus_addr == BASE && lg_n > 0 &&
                  !lg_wr[lg_n-1] && lg_addr[lg_n-1] == BASE) && lg_n < 64) begin
                lg_addr[lg_n] = bus_addr; lg_wr[lg_n] = bus_write; lg_data[lg_n] = bus_wdata;
                lg_n++;
            end
            if (bus_write && bus_addr == BASE) begin
                if (s_busy > 0) s_cmd_while_busy = 1;
                s_err = s_err_cfg; s_pend = 0; s_irqreq = bus_wdata[8];
                if (s_fake_mode) begin s_busy = 200; s_fake_irq = 1; end
                else begin s_busy = s_lat; if (s_lat == 0) s_pend = 1; end
            end
            if (bus_write && bus_addr == BASE + 32'h14 && bus_wdata[30]) s_pend = 0;
        end
        cart_irq = (s_irqreq && s_pend) || s_fake_irq;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
        end
    endtask

    task automatic ex_clear(); ex_n = 0; endtask
    task automatic ex_push(input logic [31:0] ofs, input bit wr, input logic [31:0] d);
        ex_addr[ex_n] = BASE + ofs; ex_wr[ex_n] = wr; ex_data[ex_n] = d; ex_n++;
    endtask

    // expected access order for a command that completes normally
    task automatic ex_command(input logic [7:0] id, input logic [31:0] a0, a1,
                              input bit irq, input bit skip, input bit err);
        ex_clear();
        if (!skip) begin ex_push(32'h04, 1, a0); ex_push(32'h08, 1, a1); end
        ex_push(32'h00, 0, 0);
        ex_push(32'h00, 1, {23'd0, irq, id});
        ex_push(32'h00, 0, 0);
        if (irq) ex_push(32'h14, 1, 32'h4000_0000);
        ex_push(32'h04, 0, 0);
        if (!err) ex_push(32'h08, 0, 0);
    endtask

    task automatic check_log(input string rq);
        bit ok = (lg_n == ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            if (lg_addr[i] != ex_addr[i] || lg_wr[i] != ex_wr[i] ||
                (ex_wr[i] && lg_data[i] != ex_data[i])) ok = 0;
        end
        chk(ok, {rq, " access order"}, lg_n, ex_n);
    endtask

    logic [2:0]  got_code;
    logic [31:0] got_w0, got_w1;

    task automatic run_req(input logic [1:0] op, input logic [7:0] id, input logic [31:0] a0, a1,
                           input bit irq, input bit skip);
        int cnt = 0;
        lg_n = 0;
        req_op = op; req_cmd_id = id; req_arg0 = a0; req_arg1 = a1;
        req_use_irq = irq; req_skip_args = skip; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 held off", req_ready, 0);
        while (!rsp_valid && cnt < 5000) begin @(negedge clk); cnt++; end
        got_code = rsp_code; got_w0 = rsp_word0; got_w1 = rsp_word1;
        chk(rsp_valid == 1'b1, "R11 response", rsp_valid, 1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 one clock", rsp_valid, 0);
    endtask

    task automatic slave_quiet();
        s_busy = 0; s_pend = 0; s_irqreq = 0; s_fake_irq = 0; s_fake_mode = 0;
        s_err = 0; s_err_cfg = 0; s_lat = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
        finish_up();
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(bus_valid == 1'b0, "R1 bus", bus_valid, 0);
        chk(rsp_valid == 1'b0, "R1 rsp", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: command issued while the window reports busy
        slave_quiet(); s_busy = 15; s_lat = 4; s_d0 = 32'hA; s_d1 = 32'hB;
        ex_command(8'h21, 32'h1111, 32'h2222, 0, 0, 0);
        run_req(2'd0, 8'h21, 32'h1111, 32'h2222, 0, 0);
        check_log("R3 R2 R4");
        chk(s_cmd_while_busy == 0, "R3 no write while busy", s_cmd_while_busy, 0);
        chk(got_code == 3'd0 && got_w0 == 32'hA && got_w1 == 32'hB, "R5 R7 polled result", got_w0, 32'hA);

        // R7: error path in polled mode
        slave_quiet(); s_lat = 6; s_err_cfg = 1; s_d0 = 32'hDEAD; s_d1 = 32'h77;
        ex_command(8'h05, 0, 0, 0, 1, 1);
        run_req(2'd0, 8'h05, 0, 0, 0, 1);
        check_log("R7 R2 skip");
        chk(got_code == 3'd1, "R7 code", got_code, 1);
        chk(got_w0 == 32'hDEAD && got_w1 == 32'd0, "R7 words", got_w1, 0);

        // R6: interrupt not backed by a pending bit
        slave_quiet(); s_fake_mode = 1;
        ex_clear(); ex_push(32'h00, 0, 0); ex_push(32'h00, 1, 32'h0000_0109); ex_push(32'h00, 0, 0);
        run_req(2'd0, 8'h09, 0, 0, 1, 1);
        check_log("R6 no pending");
        chk(got_code == 3'd4, "R6 code 4", got_code, 4);

        // R10: timeout in gate, poll and interrupt wait
        slave_quiet(); tmo_limit = 16'd40; s_busy = 5000;
        ex_clear(); ex_push(32'h00, 0, 0);
        run_req(2'd0, 8'h11, 0, 0, 0, 1);
        check_log("R10 gate");
        chk(got_code == 3'd2, "R10 gate code", got_code, 2);

        slave_quiet(); s_lat = 5000;
        ex_clear(); ex_push(32'h00, 0, 0); ex_push(32'h00, 1, 32'h12); ex_push(32'h00, 0, 0);
        run_req(2'd0, 8'h12, 0, 0, 0, 1);
        check_log("R10 poll");
        chk(got_code == 3'd2 && got_w0 == 0, "R10 poll code", got_code, 2);

        slave_quiet(); s_lat = 5000;
        ex_clear(); ex_push(32'h00, 0, 0); ex_push(32'h00, 1, 32'h113);
        run_req(2'd0, 8'h13, 0, 0, 1, 1);
        check_log("R10 irq");
        chk(got_code == 3'd2, "R10 irq code", got_code, 2);
        slave_quiet(); tmo_limit = 16'hFFFF;

        // R8: probe
        s_busy = 8; s_id = MAGIC;
        ex_clear(); ex_push(32'h0C, 0, 0); ex_push(32'h00, 0, 0);
        run_req(2'd1, 0, 0, 0, 0, 0);
        check_log("R8 present");
        chk(got_code == 3'd0 && got_w0 == MAGIC, "R8 present word", got_w0, MAGIC);
        slave_quiet(); s_id = 32'h1234_5678;
        ex_clear(); ex_push(32'h0C, 0, 0);
        run_req(2'd1, 0, 0, 0, 0, 0);
        check_log("R8 absent");
        chk(got_code == 3'd3 && got_w0 == 32'h1234_5678, "R8 absent", got_w0, 32'h1234_5678);

        // R9: key writes
        ex_clear(); ex_push(32'h10, 1, KEY_A); ex_push(32'h10, 1, 32'h4F43_4B5F);
        run_req(2'd2, 0, 0, 0, 0, 0);
        check_log("R9 unlock");
        chk(got_code == 3'd0, "R9 unlock code", got_code, 0);
        ex_clear(); ex_push(32'h10, 1, 32'hFFFF_FFFF);
        run_req(2'd3, 0, 0, 0, 0, 0);
        check_log("R9 lock");
        chk(got_code == 3'd0, "R9 lock code", got_code, 0);

        // R12 plus mixed random commands (bus stalls are random throughout)
        for (int i = 0; i < 24; i++) begin
            logic [7:0]  id = 8'($urandom);
            logic [31:0] a0 = $urandom, a1 = $urandom;
            bit irq = 1'($urandom), skip = 1'($urandom), err = ($urandom % 4 == 0);
            slave_quiet();
            s_lat = (i < 3) ? 0 : int'($urandom % 12);
            s_err_cfg = err; s_d0 = $urandom; s_d1 = $urandom;
            ex_command(id, a0, a1, irq, skip, err);
            run_req(2'd0, id, a0, a1, irq, skip);
            check_log(irq ? "R6 R12 random" : "R5 R12 random");
            chk(got_code == (err ? 3'd1 : 3'd0), "R7 random code", got_code, err);
            chk(got_w0 == s_d0 && got_w1 == (err ? 32'd0 : s_d1), "R7 random words", got_w1, err ? 0 : s_d1);
            chk(cart_irq == 1'b0 || !irq, "R6 acknowledged", cart_irq, 0);
        end
        chk(s_cmd_while_busy == 0, "R3 overall", s_cmd_while_busy, 0);
        finish_up();
    end

endmodule